// File: doc/BRIEF.md
# Secure-World Escalating Watchdog

This block protects privileged software from being starved by less trusted code running on the same processor. Secure software programs two intervals and then turns the watchdog on. From then on it has to feed the watchdog at regular intervals. If it misses the first deadline, the block raises an interrupt meant to be routed to the secure world, so that the processor is forced into secure mode. If the secure side still does not feed the watchdog before a second, grace deadline, the block raises a security-violation flag. That flag stays set until the next reset.

Every register write carries a secure or non-secure attribute. A non-secure write changes nothing and sets a sticky access-error flag. This covers writes to the intervals, the enable and the feed register. The enable bit can only be set. Once it is set, only reset clears it. Feeding the watchdog takes two secure writes in order to the feed register: 0x5555, then 0xAAAA.

Top module: `swdt_secure_top`

## Requirements
- R1: After reset the control readback (address 0) is 0, both interval registers (addresses 1 and 2) read 0xFFFF, and `irq_secure`, `violation` and `access_err` are low.
- R2: A secure write with bit 0 set to the control register (address 0) turns the watchdog on. No later write clears it; only reset does. The control readback holds enable in bit 0, the pending interrupt in bit 1, the violation in bit 2 and the access error in bit 3.
- R3: A write with `bus_sec` low leaves every register and the counting unchanged, and sets `access_err`, which stays high until reset.
- R4: `irq_secure` rises on the clock edge that comes T+1 edges after the start edge, where T is the first-stage interval at address 1. The start edge is the edge of the enabling write or of the last valid feed.
- R5: If no valid feed follows, `violation` rises G+1 edges after the edge on which `irq_secure` rose, where G is the grace interval at address 2.
- R6: A valid feed is a secure write of 0x5555 to the feed register (address 3) followed, with no other feed-register write in between, by a secure write of 0xAAAA. Any other value written to address 3 breaks the pair.
- R7: A valid feed in either stage clears `irq_secure` on its own edge and restarts the first-stage interval from that edge.
- R8: Once `violation` is high, it stays high until reset, whatever feeds follow.
- R9: While the watchdog is off, `irq_secure` and `violation` stay low, whatever the interval values and feed writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sec | input | 1 | Secure attribute of the current access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_secure | output | 1 | First-stage timeout interrupt for the secure world |
| violation | output | 1 | Latched security-violation flag |
| access_err | output | 1 | Sticky flag for a rejected non-secure write |

## Verification
The bench sweeps small pairs of interval values, zero included, and checks that each stage fires on exactly the predicted edge. An off-by-one in the reload or in the zero test would show up there as an early or late interrupt or violation. It also feeds the watchdog with broken key pairs and with pairs whose second write is non-secure; a loose key check would accept these and delay the interrupt. Other cases check that a feed during the grace stage clears the interrupt but not a violation that has already been raised. The last cases check that non-secure writes neither reprogram nor enable the block, and that a secure zero write to the control register does not turn the watchdog off.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_GRACE   = 2'd2,
    ST_TRIPPED = 2'd3
  } swdt_stage_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_TMO   = 1;
  localparam int unsigned REG_GRACE = 2;
  localparam int unsigned REG_KICK  = 3;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IRQ_BIT  = 1;
  localparam int unsigned CTRL_VIOL_BIT = 2;
  localparam int unsigned CTRL_AERR_BIT = 3;
  localparam int unsigned CTRL_BITS     = 4;
endpackage

// File: rtl/swdt_rst_sync.sv
module swdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/swdt_keyseq.sv
module swdt_keyseq #(
  parameter int unsigned    DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_B = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              kick_wr,
  input  logic [DATA_W-1:0] kick_data,
  output logic              kick_ok
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    kick_ok = 1'b0;
    if (kick_wr) begin
      kick_ok = armed_q && (kick_data == KEY_B);
      armed_d = (kick_data == KEY_A);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end
endmodule

// File: rtl/swdt_regs.sv
module swdt_regs
  import swdt_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADDR_W    = 3,
  parameter logic [DATA_W-1:0] RST_TMO   = 16'hFFFF,
  parameter logic [DATA_W-1:0] RST_GRACE = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bus_wr,
  input  logic              bus_sec,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              enabled,
  output logic              start,
  output logic              kick_wr,
  output logic [DATA_W-1:0] tmo_val,
  output logic [DATA_W-1:0] grace_val,
  output logic              access_err
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO   = ADDR_W'(REG_TMO);
  localparam logic [ADDR_W-1:0] A_GRACE = ADDR_W'(REG_GRACE);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(REG_KICK);

  logic              en_q, en_d;
  logic              aerr_q, aerr_d;
  logic [DATA_W-1:0] tmo_q, tmo_d;
  logic [DATA_W-1:0] grace_q, grace_d;
  logic              sec_wr, tmo_ce, grace_ce;

  assign sec_wr = bus_wr && bus_sec;

  always_comb begin
    en_d     = en_q;
    aerr_d   = aerr_q;
    tmo_d    = tmo_q;
    grace_d  = grace_q;
    tmo_ce   = 1'b0;
    grace_ce = 1'b0;
    start    = 1'b0;
    kick_wr  = 1'b0;
    if (bus_wr && !bus_sec) begin
      aerr_d = 1'b1;
    end else if (sec_wr) begin
      case (bus_addr)
        A_CTRL: begin
          if (bus_wdata[CTRL_EN_BIT] && !en_q) begin
            en_d  = 1'b1;
            start = 1'b1;
          end
        end
        A_TMO: begin
          tmo_ce = 1'b1;
          tmo_d  = bus_wdata;
        end
        A_GRACE: begin
          grace_ce = 1'b1;
          grace_d  = bus_wdata;
        end
        A_KICK:  kick_wr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q   <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      aerr_q <= aerr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     tmo_q <= RST_TMO;
    else if (tmo_ce) tmo_q <= tmo_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       grace_q <= RST_GRACE;
    else if (grace_ce) grace_q <= grace_d;
  end

  assign enabled    = en_q;
  assign access_err = aerr_q;
  assign tmo_val    = tmo_q;
  assign grace_val  = grace_q;
endmodule

// File: rtl/swdt_timer.sv
module swdt_timer
  import swdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             enabled,
  input  logic             start,
  input  logic             kick_ok,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic [CNT_W-1:0] grace_val,
  output logic             irq,
  output logic             viol,
  output logic [CNT_W-1:0] cnt,
  output swdt_stage_e      stage
);
  swdt_stage_e      stage_q, stage_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             viol_q, viol_d;
  logic             at_zero, reload;

  assign at_zero = (cnt_q == '0);
  assign reload  = start || (enabled && kick_ok);

  always_comb begin
    stage_d = stage_q;
    cnt_d   = cnt_q;
    irq_d   = irq_q;
    viol_d  = viol_q;
    if (reload) begin
      stage_d = ST_RUN;
      cnt_d   = tmo_val;
      irq_d   = 1'b0;
    end else if (enabled) begin
      case (stage_q)
        ST_RUN: begin
          if (at_zero) begin
            stage_d = ST_GRACE;
            cnt_d   = grace_val;
            irq_d   = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_GRACE: begin
          if (at_zero) begin
            stage_d = ST_TRIPPED;
            viol_d  = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      viol_q  <= viol_d;
    end
  end

  assign irq   = irq_q;
  assign viol  = viol_q;
  assign cnt   = cnt_q;
  assign stage = stage_q;
endmodule

// File: rtl/swdt_secure_top.sv
module swdt_secure_top
  import swdt_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADDR_W    = 3,
  parameter int unsigned       SYNC_STG  = 2,
  parameter logic [DATA_W-1:0] KEY_A     = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_B     = 16'hAAAA,
  parameter logic [DATA_W-1:0] RST_TMO   = 16'hFFFF,
  parameter logic [DATA_W-1:0] RST_GRACE = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sec,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_secure,
  output logic              violation,
  output logic              access_err
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO   = ADDR_W'(REG_TMO);
  localparam logic [ADDR_W-1:0] A_GRACE = ADDR_W'(REG_GRACE);

  logic              rst_sn;
  logic              enabled, start, kick_wr, kick_ok;
  logic [DATA_W-1:0] tmo_val, grace_val, cnt;
  swdt_stage_e       stage;
  logic [CTRL_BITS-1:0] ctrl_rd;

  swdt_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  swdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_TMO(RST_TMO), .RST_GRACE(RST_GRACE)
  ) u_regs (
    .clk(clk), .rst_sn(rst_sn), .bus_wr(bus_wr), .bus_sec(bus_sec),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .enabled(enabled),
    .start(start), .kick_wr(kick_wr), .tmo_val(tmo_val),
    .grace_val(grace_val), .access_err(access_err)
  );

  swdt_keyseq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_sn(rst_sn), .kick_wr(kick_wr), .kick_data(bus_wdata),
    .kick_ok(kick_ok)
  );

  swdt_timer #(.CNT_W(DATA_W)) u_timer (
    .clk(clk), .rst_sn(rst_sn), .enabled(enabled), .start(start),
    .kick_ok(kick_ok), .tmo_val(tmo_val), .grace_val(grace_val),
    .irq(irq_secure), .viol(violation), .cnt(cnt), .stage(stage)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_EN_BIT]   = enabled;
    ctrl_rd[CTRL_IRQ_BIT]  = irq_secure;
    ctrl_rd[CTRL_VIOL_BIT] = violation;
    ctrl_rd[CTRL_AERR_BIT] = access_err;
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_rd);
      A_TMO:   bus_rdata = tmo_val;
      A_GRACE: bus_rdata = grace_val;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/swdt_checker.sv
module swdt_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              bus_wr,
  input logic              bus_sec,
  input logic              enabled,
  input logic              kick_ok,
  input logic              irq,
  input logic              violation,
  input logic              access_err,
  input logic [DATA_W-1:0] tmo_val,
  input logic [DATA_W-1:0] grace_val,
  input logic [DATA_W-1:0] cnt
);
  p_enable_held_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    enabled |=> enabled);

  p_nonsec_ignored_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && !bus_sec) |=> (access_err && $stable(tmo_val) && $stable(grace_val)));

  p_aerr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    access_err |=> access_err);

  p_irq_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq) |-> ($past(cnt) == '0));

  p_viol_after_irq_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(violation) |-> irq);

  p_kick_secure_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    kick_ok |-> (bus_wr && bus_sec));

  p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (kick_ok && enabled) |=> !irq);

  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    violation |=> violation);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !enabled |-> (!irq && !violation));
endmodule

bind swdt_secure_top swdt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_wr(bus_wr), .bus_sec(bus_sec),
  .enabled(enabled), .kick_ok(kick_ok), .irq(irq_secure),
  .violation(violation), .access_err(access_err), .tmo_val(tmo_val),
  .grace_val(grace_val), .cnt(cnt)
);

// File: tb/swdt_secure_top_bench.sv
module swdt_secure_top_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_sec;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_secure;
  logic        violation;
  logic        access_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_TMO = 3'd1, A_GRACE = 3'd2, A_KICK = 3'd3;

  swdt_secure_top u_swdt_secure_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sec(bus_sec),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_secure(irq_secure), .violation(violation), .access_err(access_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_sec = 1'b1; bus_addr = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_sec = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_sec = 1'b1;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic kick();
    wr(A_KICK, 16'h5555, 1'b1);
    wr(A_KICK, 16'hAAAA, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int e, k;
    rst_n = 1'b0; bus_wr = 1'b0; bus_sec = 1'b1; bus_addr = '0; bus_wdata = '0;

    do_reset();
    rd(A_CTRL, v);  chk("R1 ctrl after reset", v, 16'h0000);
    rd(A_TMO, v);   chk("R1 tmo after reset", v, 16'hFFFF);
    rd(A_GRACE, v); chk("R1 grace after reset", v, 16'hFFFF);
    chk("R1 outputs after reset", {13'b0, irq_secure, violation, access_err}, 16'h0);

    // R4 / R5 sweep over small interval pairs
    for (int t = 0; t < 4; t++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset();
        wr(A_TMO, 16'(t), 1'b1);
        wr(A_GRACE, 16'(g), 1'b1);
        wr(A_CTRL, 16'h0001, 1'b1);
        e = last_edge;
        wait_to(e + t);         chk("R4 irq before deadline", 16'(irq_secure), 16'h0);
        wait_to(e + t + 1);     chk("R4 irq at deadline", 16'(irq_secure), 16'h1);
        wait_to(e + t + 1 + g); chk("R5 violation before grace end", 16'(violation), 16'h0);
        wait_to(e + t + 2 + g); chk("R5 violation at grace end", 16'(violation), 16'h1);
      end
    end

    // R6 / R7 valid feed in first stage restarts interval
    do_reset();
    wr(A_TMO, 16'd10, 1'b1); wr(A_GRACE, 16'd10, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1);
    kick(); k = last_edge;
    wait_to(k + 10); chk("R6 feed delays irq", 16'(irq_secure), 16'h0);
    wait_to(k + 11); chk("R7 irq after restart", 16'(irq_secure), 16'h1);

    // R6 broken pair does not feed
    do_reset();
    wr(A_TMO, 16'd12, 1'b1); wr(A_GRACE, 16'd4, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1); e = last_edge;
    wr(A_KICK, 16'h5555, 1'b1); wr(A_KICK, 16'h1234, 1'b1); wr(A_KICK, 16'hAAAA, 1'b1);
    wait_to(e + 12); chk("R6 broken pair before deadline", 16'(irq_secure), 16'h0);
    wait_to(e + 13); chk("R6 broken pair no feed", 16'(irq_secure), 16'h1);

    // R3 / R6 non-secure second key write does not feed
    do_reset();
    wr(A_TMO, 16'd12, 1'b1); wr(A_GRACE, 16'd4, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1); e = last_edge;
    wr(A_KICK, 16'h5555, 1'b1); wr(A_KICK, 16'hAAAA, 1'b0);
    wait_to(e + 13); chk("R3 nonsecure feed ignored", 16'(irq_secure), 16'h1);
    chk("R3 access error set by feed", 16'(access_err), 16'h1);

    // R7 feed during grace stage
    do_reset();
    wr(A_TMO, 16'd3, 1'b1); wr(A_GRACE, 16'd8, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1); e = last_edge;
    wait_to(e + 4); chk("R7 irq pending before feed", 16'(irq_secure), 16'h1);
    kick(); k = last_edge;
    chk("R7 irq cleared by feed", 16'(irq_secure), 16'h0);
    wait_to(k + 3); chk("R7 restarted first stage", 16'(irq_secure), 16'h0);
    wait_to(k + 4); chk("R7 irq again after restart", 16'(irq_secure), 16'h1);
    chk("R7 no violation after grace feed", 16'(violation), 16'h0);

    // R8 violation sticky across feed
    do_reset();
    wr(A_TMO, 16'd1, 1'b1); wr(A_GRACE, 16'd1, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1); e = last_edge;
    wait_to(e + 5); chk("R8 violation raised", 16'(violation), 16'h1);
    kick(); k = last_edge;
    chk("R8 violation held after feed", 16'(violation), 16'h1);
    chk("R8 irq cleared by feed", 16'(irq_secure), 16'h0);
    wait_to(k + 6); chk("R8 violation still held", 16'(violation), 16'h1);
    do_reset();
    chk("R1 violation cleared by reset", 16'(violation), 16'h0);

    // R2 enable cannot be cleared
    do_reset();
    wr(A_TMO, 16'd200, 1'b1);
    wr(A_CTRL, 16'h0001, 1'b1);
    wr(A_CTRL, 16'h0000, 1'b1);
    rd(A_CTRL, v); chk("R2 enable held after secure zero", v, 16'h0001);
    wr(A_CTRL, 16'h0000, 1'b0);
    rd(A_CTRL, v); chk("R2 enable held after nonsecure zero", v & 16'h0001, 16'h0001);

    // R3 non-secure programming rejected
    do_reset();
    wr(A_TMO, 16'd7, 1'b0);
    rd(A_TMO, v); chk("R3 tmo unchanged", v, 16'hFFFF);
    chk("R3 access_err set", 16'(access_err), 16'h1);
    wr(A_CTRL, 16'h0001, 1'b0);
    rd(A_CTRL, v); chk("R3 enable refused, aerr bit", v, 16'h0008);
    wr(A_GRACE, 16'd3, 1'b1);
    rd(A_GRACE, v); chk("R3 secure write still works", v, 16'h0003);
    chk("R3 access_err sticky", 16'(access_err), 16'h1);

    // R9 idle watchdog stays quiet
    do_reset();
    wr(A_TMO, 16'd0, 1'b1); wr(A_GRACE, 16'd0, 1'b1);
    kick();
    repeat (10) @(negedge clk);
    chk("R9 no irq while off", 16'(irq_secure), 16'h0);
    chk("R9 no violation while off", 16'(violation), 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule